// File: doc/BRIEF.md
# Stagewise Regression Iteration Controller

This block is the digital side of a hybrid sparse-coding engine. It fits one 64-sample signal (an 8x8 image patch) as a sparse combination of 256 dictionary atoms, using forward stagewise regression. An external analog array computes approximate correlations. The block itself keeps the target, the prediction and the coefficients in full precision.

Software first writes the target samples through an indexed write port. It then pulses `start`, and the block clears its state and begins iterating. Each iteration has four steps:

- The block streams the current residual out as signed 4-bit codes with a shared power-of-two scale.
- It accepts 256 correlation scores on a valid/ready stream and picks the atom with the largest score magnitude.
- It moves that atom's coefficient by a fixed step in the direction of the score's sign.
- It reads the atom's 64 full-precision samples from a dictionary read port and updates the prediction.

The run ends when the residual energy falls below a threshold or when the iteration budget is used up. The coefficients can then be read back through an indexed read port.

Top module: `fsr_iter_ctrl`

## Requirements
- R1: An accepted `start` clears all 256 coefficients and all 64 prediction samples to zero before the first iteration. Results of an earlier patch never leak into a new one.
- R2: Each iteration emits exactly 64 residual codes, one per cycle with `res_valid` high, in sample order 0..63. Each code is the residual (saturated `target - prediction`) arithmetically shifted right by the iteration's exponent, clamped to [-8, 7], and sent as 4-bit two's complement on `res_code`.
- R3: The exponent on `res_shift` is the smallest value s such that the largest residual magnitude shifted right by s is at most 7. It is recomputed before every iteration and held constant across that iteration's 64 codes.
- R4: `corr_ready` is high only in the scoring phase. Exactly 256 scores (signed 12-bit) are taken per iteration, on cycles where `corr_valid` and `corr_ready` are both high, and they are bound to atom indices 0..255 in arrival order.
- R5: The winning atom is the one whose score has the largest magnitude. On equal magnitudes the lower index wins. If every score is zero, atom 0 wins with a positive sign.
- R6: The winner's coefficient changes by +`step_size` if its score is zero or positive, and by -`step_size` if negative. The result saturates at the signed 16-bit limits.
- R7: The prediction update reads the winner's 64 samples. `dict_rd_en` is raised with `dict_atom` and `dict_sample`, and `dict_data` is taken one cycle later. For each sample, the signed change (step x sample) >>> 12 (arithmetic) is added to the prediction, saturating at the signed 16-bit limits.
- R8: Before each iteration, the sum of squared residuals is compared with `conv_thresh`. If the sum is strictly below it, the run stops with `converged` = 1. Otherwise, if the count of completed iterations equals `max_iter`, the run stops with `converged` = 0.
- R9: At termination, `done` is high for exactly one cycle. `iter_count` and `converged` then hold until the next start.
- R10: While busy, `start` is ignored. `step_size`, `max_iter` and `conv_thresh` are captured at the accepted start, and later changes to them have no effect on the run.
- R11: `coef_rdata` returns the coefficient selected by `coef_raddr` one cycle after the address is presented.
- R12: After reset, `busy`, `done`, `res_valid`, `corr_ready`, `dict_rd_en`, `converged` and `iter_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tgt_we | input | 1 | Target sample write enable |
| tgt_addr | input | 6 | Target sample index |
| tgt_data | input | 16 | Target sample, signed |
| start | input | 1 | Begin a patch (ignored while busy) |
| step_size | input | 16 | Unsigned step, 12 fractional bits |
| max_iter | input | 16 | Iteration budget |
| conv_thresh | input | 38 | Residual energy threshold, unsigned |
| busy | output | 1 | Patch in progress |
| res_valid | output | 1 | Residual code valid |
| res_idx | output | 6 | Sample index of the current code |
| res_code | output | 4 | Signed residual code |
| res_shift | output | 4 | Shared scale exponent |
| corr_valid | input | 1 | Score valid |
| corr_ready | output | 1 | Score accepted when high with valid |
| corr_score | input | 12 | Signed correlation score |
| dict_rd_en | output | 1 | Dictionary read request |
| dict_atom | output | 8 | Dictionary atom index |
| dict_sample | output | 6 | Dictionary sample index |
| dict_data | input | 16 | Dictionary sample, signed, one cycle after request |
| done | output | 1 | One-cycle termination pulse |
| iter_count | output | 16 | Iterations completed |
| converged | output | 1 | 1 if stopped by threshold, 0 if by budget |
| coef_raddr | input | 8 | Coefficient read index |
| coef_rdata | output | 16 | Coefficient, signed, registered |

## Verification
The bench drives several patch shapes, each aimed at a corner case:

- **Tied scores.** The dictionary's upper half mirrors its lower half, some atoms with opposite sign, so every score appears twice with equal magnitude. A selector that let the later index win would pick atoms above 127 and put non-zero coefficients there.
- **All-zero target.** With a zero threshold, every score is zero. A design without the zero-score rule would pick a different atom or step negative.
- **Full-scale target.** Samples at +32767 and -32768 force the widest exponent and push the prediction and coefficients into saturation. A wrapping adder would flip signs and derail the code stream.
- **Zero target, small threshold, and zero budget.** These probe the order of the two stop tests: one must stop after zero iterations as converged, the other as budget-limited.
- **Parameter changes mid-run.** Start pulses and new parameters arrive during a run. A controller that restarted or re-sampled its parameters would produce a different iteration count and code stream.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_SCAN,
    ST_CHECK,
    ST_SEND,
    ST_CORR,
    ST_COEF,
    ST_UPD,
    ST_FIN
  } fsr_state_e;

endpackage

// File: rtl/fsr_sat_add.sv
// Saturating signed add or subtract: y = sat(a +/- b) to OW bits.
module fsr_sat_add #(
  parameter int AW = 16,
  parameter int BW = 16,
  parameter int OW = 16
) (
  input  logic signed [AW-1:0] a,
  input  logic signed [BW-1:0] b,
  input  logic                 neg,
  output logic signed [OW-1:0] y
);
  localparam int SW = ((AW > BW) ? AW : BW) + 2;
  localparam logic signed [SW-1:0] HI = SW'((64'sd1 <<< (OW-1)) - 64'sd1);
  localparam logic signed [SW-1:0] LO = -HI - SW'(1);

  logic signed [SW-1:0] ax;
  logic signed [SW-1:0] bx;
  logic signed [SW-1:0] sum;

  always_comb begin
    ax  = SW'(a);
    bx  = SW'(b);
    sum = neg ? (ax - bx) : (ax + bx);
    if (sum > HI)      y = HI[OW-1:0];
    else if (sum < LO) y = LO[OW-1:0];
    else               y = sum[OW-1:0];
  end
endmodule

// File: rtl/fsr_scaler.sv
// Picks the power-of-two exponent for the residual and quantizes one sample.
module fsr_scaler #(
  parameter int DW     = 16,
  parameter int CODE_W = 4,
  parameter int SHW    = 4
) (
  input  logic [DW-1:0]        maxmag,
  input  logic signed [DW-1:0] value,
  input  logic [SHW-1:0]       shift_q,
  output logic [SHW-1:0]       shift_pick,
  output logic [CODE_W-1:0]    code
);
  localparam int CMAX = (1 << (CODE_W-1)) - 1;
  localparam logic signed [DW-1:0] HI_C = DW'(CMAX);
  localparam logic signed [DW-1:0] LO_C = -HI_C - DW'(1);

  logic signed [DW-1:0] shifted;

  // smallest exponent that brings the peak magnitude into code range
  always_comb begin
    shift_pick = SHW'(DW-1);
    for (int i = DW-1; i >= 0; i--) begin
      if ((maxmag >> i) <= DW'(CMAX)) shift_pick = SHW'(i);
    end
  end

  assign shifted = value >>> shift_q;

  always_comb begin
    if (shifted > HI_C)      code = HI_C[CODE_W-1:0];
    else if (shifted < LO_C) code = LO_C[CODE_W-1:0];
    else                     code = shifted[CODE_W-1:0];
  end
endmodule

// File: rtl/fsr_argmax.sv
// Streaming largest-magnitude tracker; strict compare keeps the lower index on ties.
module fsr_argmax #(
  parameter int N  = 256,
  parameter int SW = 12,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          clr,
  input  logic          acc,
  input  logic [SW-1:0] score,
  output logic [AW-1:0] win_idx,
  output logic          win_neg,
  output logic          last
);
  logic [AW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] best_q, best_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          neg_q, neg_d;
  logic [SW-1:0] mag;

  assign mag  = score[SW-1] ? SW'(-$signed(score)) : score;
  assign last = acc && (cnt_q == AW'(N-1));

  always_comb begin
    cnt_d  = cnt_q;
    best_d = best_q;
    idx_d  = idx_q;
    neg_d  = neg_q;
    if (clr) begin
      cnt_d  = '0;
      best_d = '0;
      idx_d  = '0;
      neg_d  = 1'b0;
    end else if (acc) begin
      cnt_d = cnt_q + 1'b1;
      if (mag > best_q) begin
        best_d = mag;
        idx_d  = cnt_q;
        neg_d  = score[SW-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      best_q <= '0;
      idx_q  <= '0;
      neg_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      best_q <= best_d;
      idx_q  <= idx_d;
      neg_q  <= neg_d;
    end
  end

  assign win_idx = idx_q;
  assign win_neg = neg_q;

  // R5
  best_grows_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc && !clr) |=> (best_q >= $past(mag)));

endmodule

// File: rtl/fsr_iter_ctrl.sv
module fsr_iter_ctrl
  import fsr_pkg::*;
#(
  parameter int N_SAMP  = 64,
  parameter int N_ATOM  = 256,
  parameter int DW      = 16,
  parameter int CODE_W  = 4,
  parameter int SCORE_W = 12,
  parameter int FRAC    = 12,
  parameter int ITER_W  = 16,
  localparam int SAMP_AW = $clog2(N_SAMP),
  localparam int ATOM_AW = $clog2(N_ATOM),
  localparam int SHW     = $clog2(DW),
  localparam int EN_W    = 2*DW + SAMP_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tgt_we,
  input  logic [SAMP_AW-1:0] tgt_addr,
  input  logic [DW-1:0]      tgt_data,
  input  logic               start,
  input  logic [DW-1:0]      step_size,
  input  logic [ITER_W-1:0]  max_iter,
  input  logic [EN_W-1:0]    conv_thresh,
  output logic               busy,
  output logic               res_valid,
  output logic [SAMP_AW-1:0] res_idx,
  output logic [CODE_W-1:0]  res_code,
  output logic [SHW-1:0]     res_shift,
  input  logic               corr_valid,
  output logic               corr_ready,
  input  logic [SCORE_W-1:0] corr_score,
  output logic               dict_rd_en,
  output logic [ATOM_AW-1:0] dict_atom,
  output logic [SAMP_AW-1:0] dict_sample,
  input  logic [DW-1:0]      dict_data,
  output logic               done,
  output logic [ITER_W-1:0]  iter_count,
  output logic               converged,
  input  logic [ATOM_AW-1:0] coef_raddr,
  output logic [DW-1:0]      coef_rdata
);
  localparam int IDX_W  = SAMP_AW + 1;
  localparam int PROD_W = 2*DW + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ni <= rst_s1;
    end
  end

  // storage
  logic signed [DW-1:0] tgt_mem  [N_SAMP];
  logic signed [DW-1:0] pred_mem [N_SAMP];
  logic signed [DW-1:0] coef_mem [N_ATOM];

  // control state
  fsr_state_e         st_q, st_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [ITER_W-1:0]  iter_q, iter_d;
  logic               conv_q, conv_d;
  logic [SHW-1:0]     shift_q, shift_d;
  logic [EN_W-1:0]    en_q, en_d;
  logic [DW-1:0]      mx_q, mx_d;
  logic [DW-1:0]      eps_q, eps_d;
  logic [ITER_W-1:0]  mi_q, mi_d;
  logic [EN_W-1:0]    th_q, th_d;
  logic [DW-1:0]      crd_q;

  logic               clear_all;
  logic               am_clr;
  logic               am_acc;
  logic               am_last;
  logic [ATOM_AW-1:0] win_idx;
  logic               win_neg;
  logic               coef_we;
  logic               pred_we;

  logic [SAMP_AW-1:0]      sel;
  logic [SAMP_AW-1:0]      pidx;
  logic signed [DW-1:0]    r_cur;
  logic [DW-1:0]           rmag;
  logic signed [2*DW-1:0]  rsq;
  logic [SHW-1:0]          shift_pick;
  logic [CODE_W-1:0]       code;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] delta;
  logic signed [DW-1:0]    pred_new;
  logic signed [DW-1:0]    coef_new;
  logic signed [DW:0]      eps_ext;

  assign sel  = SAMP_AW'(idx_q);
  assign pidx = SAMP_AW'(idx_q - 1'b1);

  // residual of the selected sample
  fsr_sat_add #(.AW(DW), .BW(DW), .OW(DW)) u_res (
    .a   (tgt_mem[sel]),
    .b   (pred_mem[sel]),
    .neg (1'b1),
    .y   (r_cur)
  );

  assign rmag = r_cur[DW-1] ? DW'(-r_cur) : DW'(r_cur);
  assign rsq  = r_cur * r_cur;

  fsr_scaler #(.DW(DW), .CODE_W(CODE_W), .SHW(SHW)) u_scale (
    .maxmag     (mx_q),
    .value      (r_cur),
    .shift_q    (shift_q),
    .shift_pick (shift_pick),
    .code       (code)
  );

  assign am_acc = corr_valid && corr_ready;

  fsr_argmax #(.N(N_ATOM), .SW(SCORE_W)) u_pick (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .clr     (am_clr),
    .acc     (am_acc),
    .score   (corr_score),
    .win_idx (win_idx),
    .win_neg (win_neg),
    .last    (am_last)
  );

  // coefficient step
  assign eps_ext = $signed({1'b0, eps_q});
  fsr_sat_add #(.AW(DW), .BW(DW+1), .OW(DW)) u_coef (
    .a   (coef_mem[win_idx]),
    .b   (eps_ext),
    .neg (win_neg),
    .y   (coef_new)
  );

  // prediction step from full-precision dictionary sample
  assign prod  = eps_ext * $signed(dict_data);
  assign delta = prod >>> FRAC;
  fsr_sat_add #(.AW(DW), .BW(PROD_W), .OW(DW)) u_pred (
    .a   (pred_mem[pidx]),
    .b   (delta),
    .neg (win_neg),
    .y   (pred_new)
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    iter_d    = iter_q;
    conv_d    = conv_q;
    shift_d   = shift_q;
    en_d      = en_q;
    mx_d      = mx_q;
    eps_d     = eps_q;
    mi_d      = mi_q;
    th_d      = th_q;
    clear_all = 1'b0;
    am_clr    = 1'b0;
    coef_we   = 1'b0;
    pred_we   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          eps_d = step_size;
          mi_d  = max_iter;
          th_d  = conv_thresh;
          st_d  = ST_CLEAR;
        end
      end
      ST_CLEAR: begin
        clear_all = 1'b1;
        iter_d    = '0;
        conv_d    = 1'b0;
        idx_d     = '0;
        en_d      = '0;
        mx_d      = '0;
        st_d      = ST_SCAN;
      end
      ST_SCAN: begin
        en_d  = en_q + EN_W'($unsigned(rsq));
        if (rmag > mx_q) mx_d = rmag;
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_W'(N_SAMP-1)) begin
          idx_d = '0;
          st_d  = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (en_q < th_q) begin
          conv_d = 1'b1;
          st_d   = ST_FIN;
        end else if (iter_q == mi_q) begin
          conv_d = 1'b0;
          st_d   = ST_FIN;
        end else begin
          shift_d = shift_pick;
          idx_d   = '0;
          st_d    = ST_SEND;
        end
      end
      ST_SEND: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_W'(N_SAMP-1)) begin
          idx_d  = '0;
          am_clr = 1'b1;
          st_d   = ST_CORR;
        end
      end
      ST_CORR: begin
        if (am_last) st_d = ST_COEF;
      end
      ST_COEF: begin
        coef_we = 1'b1;
        idx_d   = '0;
        st_d    = ST_UPD;
      end
      ST_UPD: begin
        pred_we = (idx_q != '0);
        idx_d   = idx_q + 1'b1;
        if (idx_q == IDX_W'(N_SAMP)) begin
          idx_d  = '0;
          iter_d = iter_q + 1'b1;
          en_d   = '0;
          mx_d   = '0;
          st_d   = ST_SCAN;
        end
      end
      ST_FIN: begin
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      iter_q  <= '0;
      conv_q  <= 1'b0;
      shift_q <= '0;
      en_q    <= '0;
      mx_q    <= '0;
      eps_q   <= '0;
      mi_q    <= '0;
      th_q    <= '0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      iter_q  <= iter_d;
      conv_q  <= conv_d;
      shift_q <= shift_d;
      en_q    <= en_d;
      mx_q    <= mx_d;
      eps_q   <= eps_d;
      mi_q    <= mi_d;
      th_q    <= th_d;
    end
  end

  // storage writes (no reset: cleared by the patch start)
  always_ff @(posedge clk) begin
    if (tgt_we) tgt_mem[tgt_addr] <= $signed(tgt_data);
  end

  always_ff @(posedge clk) begin
    if (clear_all) begin
      for (int i = 0; i < N_SAMP; i++) pred_mem[i] <= '0;
    end else if (pred_we) begin
      pred_mem[pidx] <= pred_new;
    end
  end

  always_ff @(posedge clk) begin
    if (clear_all) begin
      for (int i = 0; i < N_ATOM; i++) coef_mem[i] <= '0;
    end else if (coef_we) begin
      coef_mem[win_idx] <= coef_new;
    end
  end

  always_ff @(posedge clk) begin
    crd_q <= coef_mem[coef_raddr];
  end

  // outputs
  assign busy        = (st_q != ST_IDLE);
  assign done        = (st_q == ST_FIN);
  assign res_valid   = (st_q == ST_SEND);
  assign res_idx     = sel;
  assign res_code    = code;
  assign res_shift   = shift_q;
  assign corr_ready  = (st_q == ST_CORR);
  assign dict_rd_en  = (st_q == ST_UPD) && (idx_q < IDX_W'(N_SAMP));
  assign dict_atom   = win_idx;
  assign dict_sample = sel;
  assign iter_count  = iter_q;
  assign converged   = conv_q;
  assign coef_rdata  = crd_q;

  // R2
  code_order_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (res_valid && res_idx != '0) |-> ($past(res_valid) && res_idx == $past(res_idx) + 1'b1));

  // R3
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (res_valid && $past(res_valid)) |-> $stable(res_shift));

  // R7
  dict_atom_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (dict_rd_en && $past(dict_rd_en)) |-> $stable(dict_atom));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);

  // R8
  stop_reason_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && !converged) |-> (iter_count == mi_q));

  // R10
  param_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && !done) |=> ($stable(eps_q) && $stable(mi_q) && $stable(th_q)));

endmodule

// File: tb/sim_fsr_iter_ctrl.sv
`timescale 1ns/1ps
module sim_fsr_iter_ctrl;
  localparam int NS   = 64;
  localparam int NA   = 256;
  localparam int FRAC = 12;

  logic        clk;
  logic        rst_n;
  logic        tgt_we;
  logic [5:0]  tgt_addr;
  logic [15:0] tgt_data;
  logic        start;
  logic [15:0] step_size;
  logic [15:0] max_iter;
  logic [37:0] conv_thresh;
  logic        busy;
  logic        res_valid;
  logic [5:0]  res_idx;
  logic [3:0]  res_code;
  logic [3:0]  res_shift;
  logic        corr_valid;
  logic        corr_ready;
  logic [11:0] corr_score;
  logic        dict_rd_en;
  logic [7:0]  dict_atom;
  logic [5:0]  dict_sample;
  logic [15:0] dict_data;
  logic        done;
  logic [15:0] iter_count;
  logic        converged;
  logic [7:0]  coef_raddr;
  logic [15:0] coef_rdata;

  fsr_iter_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
    .start(start), .step_size(step_size), .max_iter(max_iter), .conv_thresh(conv_thresh),
    .busy(busy), .res_valid(res_valid), .res_idx(res_idx), .res_code(res_code),
    .res_shift(res_shift), .corr_valid(corr_valid), .corr_ready(corr_ready),
    .corr_score(corr_score), .dict_rd_en(dict_rd_en), .dict_atom(dict_atom),
    .dict_sample(dict_sample), .dict_data(dict_data), .done(done), .iter_count(iter_count),
    .converged(converged), .coef_raddr(coef_raddr), .coef_rdata(coef_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;

  longint tgt_vec [NS];
  longint exp_coef [NA];
  int     exp_iter;
  bit     exp_conv;
  logic [13:0] exp_q [$];
  int     score_q [$];
  int     dut_code [NS];
  bit     rdy_seen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // dictionary: upper half mirrors lower half (second quarter negated) to force ties
  function automatic int base_at(input int a, input int s);
    return ((a*7 + 3) * (s + 1) * 13 + a*a*5 + s*s) % 8191 - 4095;
  endfunction

  function automatic int dfun(input int a, input int s);
    if (a >= 192)      return -base_at(a - 128, s);
    else if (a >= 128) return base_at(a - 128, s);
    else               return base_at(a, s);
  endfunction

  function automatic longint sat16(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // behavioural analog dot product on 4-bit codes and coarse dictionary
  function automatic int score_of(input int c [NS], input int a);
    int acc = 0;
    for (int s = 0; s < NS; s++) acc += c[s] * (dfun(a, s) >>> 10);
    if (acc > 2047)  acc = 2047;
    if (acc < -2048) acc = -2048;
    return acc;
  endfunction

  always @(posedge clk) begin
    if (dict_rd_en) dict_data <= 16'(dfun(int'(dict_atom), int'(dict_sample)));
  end

  // driver side of the scoreboard: reference model pushes expected codes
  task automatic model(input longint eps, input int mi, input longint thr);
    longint pr [NS];
    longint r  [NS];
    int     mc [NS];
    longint en, mx, best, m, d, c;
    int     sh, win, sc;
    bit     neg;
    for (int a = 0; a < NA; a++) exp_coef[a] = 0;
    for (int s = 0; s < NS; s++) pr[s] = 0;
    exp_iter = 0;
    while (1) begin
      en = 0; mx = 0;
      for (int s = 0; s < NS; s++) begin
        r[s] = sat16(tgt_vec[s] - pr[s]);
        en += r[s] * r[s];
        m = (r[s] < 0) ? -r[s] : r[s];
        if (m > mx) mx = m;
      end
      if (en < thr) begin exp_conv = 1; break; end
      if (exp_iter == mi) begin exp_conv = 0; break; end
      sh = 15;
      for (int i = 15; i >= 0; i--) if ((mx >> i) <= 7) sh = i;
      for (int s = 0; s < NS; s++) begin
        c = r[s] >>> sh;
        if (c > 7)  c = 7;
        if (c < -8) c = -8;
        mc[s] = int'(c);
        exp_q.push_back({4'(sh), 6'(s), 4'(c)});
      end
      win = 0; best = 0; neg = 0;
      for (int a = 0; a < NA; a++) begin
        sc = score_of(mc, a);
        m = (sc < 0) ? -sc : sc;
        if (m > best) begin best = m; win = a; neg = (sc < 0); end
      end
      exp_coef[win] = sat16(exp_coef[win] + (neg ? -eps : eps));
      for (int s = 0; s < NS; s++) begin
        d = (eps * dfun(win, s)) >>> FRAC;
        pr[s] = sat16(pr[s] + (neg ? -d : d));
      end
      exp_iter++;
    end
  endtask

  // monitor and score feeder
  always @(negedge clk) begin
    logic [13:0] e;
    int          tmp;
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected residual code at index", res_idx, -1);
      end else begin
        e = exp_q.pop_front();
        chk(res_shift == e[13:10], "R3", "exponent", res_shift, e[13:10]);
        chk(res_idx == e[9:4] && res_code == e[3:0], "R2", "code {idx,code}",
            {res_idx, res_code}, e[9:0]);
      end
      dut_code[res_idx] = int'($signed(res_code));
      if (res_idx == 6'd63) begin
        for (int a = 0; a < NA; a++) score_q.push_back(score_of(dut_code, a));
      end
    end
    if (corr_valid && rdy_seen) tmp = score_q.pop_front();
    rdy_seen = corr_ready;
    if (score_q.size() > 0 && $urandom_range(0, 3) != 0) begin
      corr_valid = 1'b1;
      corr_score = 12'(score_q[0]);
    end else begin
      corr_valid = 1'b0;
    end
  end

  task automatic run_patch(input string nm, input longint eps, input int mi,
                           input longint thr, input bit poke);
    int cyc;
    for (int s = 0; s < NS; s++) begin
      @(negedge clk);
      tgt_we = 1'b1; tgt_addr = 6'(s); tgt_data = 16'(tgt_vec[s]);
    end
    @(negedge clk);
    tgt_we = 1'b0;
    model(eps, mi, thr);
    step_size = 16'(eps); max_iter = 16'(mi); conv_thresh = 38'(thr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10: new parameters and a second start while busy must have no effect
      repeat (300) @(negedge clk);
      max_iter = 16'd2; step_size = 16'd1; conv_thresh = '1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 40000) begin @(negedge clk); cyc++; end
    chk(done, "R9", {nm, " done pulse"}, done, 1);
    chk(iter_count == 16'(exp_iter), "R8", {nm, " iteration count"}, iter_count, exp_iter);
    chk(converged == exp_conv, "R8", {nm, " stop reason"}, converged, exp_conv);
    @(negedge clk);
    chk(!done, "R9", {nm, " done width"}, done, 0);
    chk(iter_count == 16'(exp_iter), "R9", {nm, " count held"}, iter_count, exp_iter);
    chk(exp_q.size() == 0, "R2", {nm, " codes left unsent"}, exp_q.size(), 0);
    for (int a = 0; a < NA; a++) begin
      coef_raddr = 8'(a);
      @(negedge clk);
      chk($signed(coef_rdata) == 16'(exp_coef[a]), "R6", $sformatf("%s coef %0d (R1 R5 R11)", nm, a),
          longint'($signed(coef_rdata)), exp_coef[a]);
    end
  endtask

  initial begin
    rst_n = 1'b0; tgt_we = 1'b0; tgt_addr = '0; tgt_data = '0; start = 1'b0;
    step_size = '0; max_iter = '0; conv_thresh = '0; corr_valid = 1'b0; corr_score = '0;
    coef_raddr = '0; dict_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(!busy && !done, "R12", "busy/done after reset", {busy, done}, 0);
    chk(!res_valid && !corr_ready && !dict_rd_en, "R12", "strobes after reset",
        {res_valid, corr_ready, dict_rd_en}, 0);
    chk(iter_count == 0 && !converged, "R12", "status after reset", iter_count, 0);

    // A: mixed target, budget stop, poked mid-run (R4 R5 R7 R10)
    for (int s = 0; s < NS; s++)
      tgt_vec[s] = (dfun(5, s) >>> 2) + (dfun(40, s) >>> 3) - (dfun(100, s) >>> 3);
    run_patch("A", 1024, 20, 1000, 1'b1);

    // B: zero target, small threshold -> converged with zero iterations, coefs cleared (R1 R8)
    for (int s = 0; s < NS; s++) tgt_vec[s] = 0;
    run_patch("B", 1024, 10, 1, 1'b0);

    // C: full-scale target, widest exponent and saturation (R3 R6 R7)
    for (int s = 0; s < NS; s++) tgt_vec[s] = (base_at(3, s) >= 0) ? 32767 : -32768;
    run_patch("C", 30000, 3, 0, 1'b0);

    // D: target built from one atom, threshold stop expected (R8)
    for (int s = 0; s < NS; s++) tgt_vec[s] = (1536 * dfun(9, s)) >>> FRAC;
    run_patch("D", 1536, 30, 102400, 1'b0);

    // E: zero target with zero threshold -> all scores tie at zero (R5)
    for (int s = 0; s < NS; s++) tgt_vec[s] = 0;
    run_patch("E", 4096, 3, 0, 1'b0);

    // F: zero budget with non-zero residual -> budget stop at zero iterations (R8)
    for (int s = 0; s < NS; s++) tgt_vec[s] = dfun(17, s);
    run_patch("F", 2048, 0, 0, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", 190000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule